// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block runs an external successive-approximation converter through sequences of four conversions and keeps the four results in registers that a bus can read. Software controls it through one 8-bit control/status register. Any write to that register starts a new sequence, and software learns that the sequence is finished by reading a completion flag. The controller gives the converter a start pulse and a channel number. The converter answers with a done strobe and 8-bit data.

There are two channel modes. In the single-channel mode the same channel is sampled four times. In the group mode a block of four adjacent channels is scanned in ascending order. Each mode can run once or repeat continuously. A suspend input stands in for a low-power state. While suspend is high the controller freezes its current slot and drops that slot's conversion. When suspend is released, that same channel is sampled again from the start.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset every bus address reads 0, no start pulse is issued and no sequence runs.
- R2: Address 0 reads {completion flag, 0, scan, group, select[3:0]}. Bits 5:0 read back the last value written and bit 6 always reads 0. Addresses 1 to 4 read result registers 1 to 4, addresses 5 to 7 read 0, and the result registers cannot be written from the bus.
- R3: A control write clears the completion flag and puts slot 1 on the converter. The start pulse comes in the cycle after the write.
- R4: Exactly one start pulse is issued per slot. The next slot's pulse comes in the cycle after its done strobe is accepted, and never earlier.
- R5: With the group bit (bit 4) clear, all four conversions use channel select[3:0], and the results go to registers 1, 2, 3 and 4 in that order.
- R6: With the group bit set, slot k (k = 0 to 3) converts channel {select[3:2], k} and stores its result in register k+1.
- R7: With the scan bit (bit 5) clear, the completion flag is set on the edge that stores the fourth result, and the controller then goes idle.
- R8: With the scan bit set, the sequence restarts at slot 1 straight after slot 4. Every result register is updated as its data arrives, and the flag stays set until the next write.
- R9: A write during a sequence abandons it. Data whose done strobe comes in the same cycle as a write is dropped, and the new sequence begins at slot 1.
- R10: While suspend is high no start pulse is issued and any done strobe is ignored. After release the interrupted slot restarts with a fresh start pulse on the same channel.
- R11: A done strobe that comes while the controller is idle, or before the slot's start pulse, changes no result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWr | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 6 | Write data for control bits 5:0 |
| rdAddr | input | 3 | Read address: 0 is control, 1 to 4 are results |
| rdData | output | 8 | Read data for rdAddr |
| suspend | input | 1 | Low-power hold request |
| convStart | output | 1 | Start pulse to the converter |
| convChan | output | 4 | Channel for the conversion being started |
| convDone | input | 1 | Conversion-finished strobe from the converter |
| convData | input | 8 | Conversion result, valid with convDone |

## Verification
The hardest cases to reach are the ones where a done strobe lands in the very cycle that would decide whether a slot completes. Examples are a control write issued exactly when the converter answers, and a suspend raised while a conversion is outstanding. The bench's converter model tracks how many cycles remain on the pending conversion. The stimulus waits until that count reaches zero and then fires the write, or raises suspend mid-wait. It also forces stray strobes while the controller is suspended, idle, or has not yet issued its start.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SEQ_SLOTS = 4;
  localparam int SLOT_W = $clog2(SEQ_SLOTS);
  localparam int RD_ADDR_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic              resWe;
    logic [SLOT_W-1:0] resIdx;
  } resStrobe_t;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [5:0]        ctrlWrData,
  input  logic              suspend,
  input  logic              convDone,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output resStrobe_t        strobe,
  output logic [7:0]        ctrlByte,
  output logic              doneFlag
);
  localparam int GRP_W = CHAN_W - SLOT_W;

  seqState_t         state;
  logic [SLOT_W-1:0] slot;
  logic              flag;
  logic              scanMode;
  logic              groupMode;
  logic [CHAN_W-1:0] chanSel;
  logic              lastSlot;
  logic              accept;

  assign lastSlot = (slot == SLOT_W'(SEQ_SLOTS - 1));
  assign accept   = !ctrlWr && (state == ST_WAIT) && !suspend && convDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slot      <= '0;
      flag      <= 1'b0;
      scanMode  <= 1'b0;
      groupMode <= 1'b0;
      chanSel   <= '0;
    end else if (ctrlWr) begin
      scanMode  <= ctrlWrData[5];
      groupMode <= ctrlWrData[4];
      chanSel   <= ctrlWrData[CHAN_W-1:0];
      flag      <= 1'b0;
      slot      <= '0;
      state     <= ST_START;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_START: begin
          if (!suspend) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (suspend) begin
            state <= ST_START;
          end else if (convDone) begin
            if (lastSlot) begin
              flag  <= 1'b1;
              slot  <= '0;
              state <= scanMode ? ST_START : ST_IDLE;
            end else begin
              slot  <= slot + 1'b1;
              state <= ST_START;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign convStart = (state == ST_START) && !suspend;
  assign convChan  = groupMode ? {chanSel[CHAN_W-1:CHAN_W-GRP_W], slot} : chanSel;

  always_comb begin
    strobe        = '0;
    strobe.resWe  = accept;
    strobe.resIdx = slot;
  end

  assign ctrlByte = {flag, 1'b0, scanMode, groupMode, chanSel};
  assign doneFlag = flag;
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  resStrobe_t           strobe,
  input  logic [DATA_W-1:0]    convData,
  input  logic [7:0]           ctrlByte,
  input  logic [RD_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]    rdData
);
  logic [DATA_W-1:0] resReg [SEQ_SLOTS];

  for (genvar g = 0; g < SEQ_SLOTS; g++) begin : g_res
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resReg[g] <= '0;
      end else if (strobe.resWe && (strobe.resIdx == SLOT_W'(g))) begin
        resReg[g] <= convData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == '0) begin
      rdData = DATA_W'(ctrlByte);
    end else if (int'(rdAddr) <= SEQ_SLOTS) begin
      rdData = resReg[SLOT_W'(rdAddr - RD_ADDR_W'(1))];
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ctrlWr,
  input  logic [5:0]           ctrlWrData,
  input  logic [RD_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]    rdData,
  input  logic                 suspend,
  output logic                 convStart,
  output logic [CHAN_W-1:0]    convChan,
  input  logic                 convDone,
  input  logic [DATA_W-1:0]    convData
);
  resStrobe_t strobe;
  logic [7:0] ctrlByte;
  logic       doneFlag;

  adc_seq_fsm #(.CHAN_W(CHAN_W)) u_fsm (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .suspend(suspend), .convDone(convDone), .convStart(convStart),
    .convChan(convChan), .strobe(strobe), .ctrlByte(ctrlByte),
    .doneFlag(doneFlag)
  );

  adc_seq_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convData(convData),
    .ctrlByte(ctrlByte), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWr,
  input logic       suspend,
  input logic       convStart,
  input logic       convDone,
  input logic [3:0] convChan,
  input logic [7:0] ctrlByte,
  input logic       doneFlag
);
  // R4: a slot gets one pulse, then waits for done
  a_r4_single_start: assert property (@(posedge clk) disable iff (!rstN)
    convStart && !ctrlWr |=> !convStart);

  // R3: a write leaves the flag clear
  a_r3_write_clears_flag: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> !doneFlag);

  // R10: nothing starts while suspended
  a_r10_no_start_suspended: assert property (@(posedge clk) disable iff (!rstN)
    suspend |-> !convStart);

  // R7: flag only rises on an edge that saw a done strobe
  a_r7_flag_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(convDone));

  // R5: single-channel mode uses the select field as is
  a_r5_single_channel: assert property (@(posedge clk) disable iff (!rstN)
    convStart && !ctrlByte[4] |-> convChan == ctrlByte[3:0]);

  // R6: group mode keeps the upper select bits
  a_r6_group_upper: assert property (@(posedge clk) disable iff (!rstN)
    convStart && ctrlByte[4] |-> convChan[3:2] == ctrlByte[3:2]);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .suspend(suspend),
  .convStart(convStart), .convDone(convDone), .convChan(convChan),
  .ctrlByte(ctrlByte), .doneFlag(doneFlag)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWr = 1'b0;
  logic [5:0] ctrlWrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       suspend = 1'b0;
  logic       convStart;
  logic [3:0] convChan;
  logic       convDone = 1'b0;
  logic [7:0] convData = '0;

  adc_seq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .rdAddr(rdAddr), .rdData(rdData), .suspend(suspend),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convData(convData)
  );

  always #4 clk = ~clk;

  int    nCompared = 0;
  int    nFailed = 0;
  int    cyc = 0;
  string phase = "R1";
  bit    finished = 0;

  // reference model state
  int       mState = 0;  // 0 idle, 1 about to start, 2 waiting
  int       mSlot = 0;
  bit       mFlag = 0;
  bit [5:0] mCtrl = '0;
  bit [7:0] mRes [4] = '{default: 8'h00};

  // converter model
  bit       cvPending = 0;
  int       cvCnt = 0;
  bit [7:0] cvData = '0;
  int       startCount = 0;

  // stimulus requests
  bit       wrReq = 0;
  bit [5:0] wrVal = '0;
  bit       suspHold = 0;
  bit       strayReq = 0;

  function automatic void check(string what, int act, int exp);
    nCompared++;
    if (act != exp) begin
      nFailed++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", phase, what, act, exp, cyc);
    end
  endfunction

  function automatic int expRead(int a);
    if (a == 0) return {mFlag, 1'b0, mCtrl};
    if (a <= 4) return mRes[a-1];
    return 0;
  endfunction

  task automatic tick();
    bit expStart;
    bit [3:0] expChan;
    bit doneNow;
    @(negedge clk);
    ctrlWr = wrReq;
    ctrlWrData = wrVal;
    suspend = suspHold;
    doneNow = (cvPending && cvCnt == 0) || strayReq;
    convDone = doneNow;
    convData = strayReq ? 8'hEE : cvData;
    strayReq = 0;
    wrReq = 0;
    rdAddr = 3'(cyc % 8);
    #1;
    expStart = (mState == 1) && !suspend;
    expChan = mCtrl[4] ? {mCtrl[3:2], 2'(mSlot)} : mCtrl[3:0];
    check("convStart", int'(convStart), int'(expStart));
    if (expStart) check("convChan", int'(convChan), int'(expChan));
    check($sformatf("rdData@%0d", rdAddr), int'(rdData), expRead(int'(rdAddr)));
    // model update
    if (ctrlWr) begin
      mCtrl = ctrlWrData; mFlag = 0; mSlot = 0; mState = 1;
    end else if (mState == 1) begin
      if (!suspend) mState = 2;
    end else if (mState == 2) begin
      if (suspend) mState = 1;
      else if (doneNow) begin
        mRes[mSlot] = convData;
        if (mSlot == 3) begin
          mFlag = 1; mSlot = 0; mState = mCtrl[5] ? 1 : 0;
        end else begin
          mSlot++; mState = 1;
        end
      end
    end
    // converter update
    if (doneNow) cvPending = 0;
    if (suspend) cvPending = 0;
    if (expStart) begin
      cvPending = 1;
      cvCnt = startCount % 4;
      cvData = 8'((int'(expChan) * 16) + startCount + 1);
      startCount++;
    end else if (cvPending && cvCnt > 0) begin
      cvCnt--;
    end
    cyc++;
  endtask

  task automatic doWrite(bit [5:0] v);
    wrReq = 1; wrVal = v;
    tick();
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 2000 && mState != 0; i++) tick();
    repeat (8) tick();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R1 reset state at the ports
    check("rdData reset", int'(rdData), 0);
    check("convStart reset", int'(convStart), 0);
    rstN = 1'b1;

    phase = "R1 R2 R11";
    repeat (8) tick();
    strayReq = 1; tick();
    repeat (8) tick();

    phase = "R2 R3 R4 R5 R7";
    doWrite(6'h05);
    waitIdle();

    phase = "R6 R7 R4";
    doWrite(6'h1B);
    waitIdle();

    phase = "R8";
    doWrite(6'h32);
    repeat (60) tick();

    phase = "R9";
    doWrite(6'h27);
    repeat (5) tick();
    for (int i = 0; i < 200 && !(cvPending && cvCnt == 0 && mState == 2); i++) tick();
    doWrite(6'h03);
    waitIdle();

    phase = "R10";
    doWrite(6'h1C);
    for (int i = 0; i < 200 && mState != 2; i++) tick();
    tick();
    suspHold = 1;
    repeat (3) tick();
    strayReq = 1; tick();
    repeat (2) tick();
    suspHold = 0;
    waitIdle();
    doWrite(6'h2A);
    repeat (3) tick();
    suspHold = 1;
    repeat (4) tick();
    suspHold = 0;
    repeat (20) tick();

    phase = "R11 R9";
    doWrite(6'h04);
    strayReq = 1; tick();
    waitIdle();
    strayReq = 1; tick();
    repeat (8) tick();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nFailed);
      $finish;
    end
  end
endmodule